// File: doc/BRIEF.md
# Reference Clock Validity Monitor

This block decides whether an incoming reference clock is usable. It runs in the local crystal clock domain and measures the time between rising edges of the reference in crystal cycles. It compares each interval against an expected interval set by a selectable reference-to-crystal ratio, within a capture window given in signed ppm. When the reference stops, runs too fast or too slow, or drifts out of the window, a valid flag drops. A hold output tells the oscillator tuning loop to freeze its last setting.

The flag is asymmetric on purpose. One bad interval, or a silence of two expected periods, clears it at once. To set it again the reference must show twelve in-range intervals in a row. The expected interval is `PRESCALE / n` crystal cycles, where `n = num/den` is the ratio picked by a 4-bit code. Integer cross-multiplication lets fractional ratios be judged without division.

Top module: `ref_valid_monitor`

## Requirements
- R1: While `rst` is high, and after reset until a full qualification completes, `ref_valid` is 0 and `hold` is 1.
- R2: `hold` is 1 exactly when `ref_valid` is 0.
- R3: `ratio_sel` picks n = num/den as follows: 0→1/8, 1→1/4, 2→1/3, 3→1/2, 4→3/4, 5→1, 6→4/3, 7→2, 8→3, 9→4, 10→6, 11→8. The expected interval is PRESCALE·den/num crystal cycles.
- R4: An interval of M crystal cycles between consecutive synchronized rising edges is in range iff M·num·(10^6+lim_lo_ppm) ≤ PRESCALE·den·10^6 ≤ M·num·(10^6+lim_hi_ppm). A reference that is never in range never sets the flag.
- R5: The flag rises on the edge that ends the 12th consecutive in-range interval, counted from the first edge after reset, a fault, or a restart. It does not rise earlier.
- R6: Any out-of-range interval clears the flag at the edge that ends that interval and restarts the count of good intervals.
- R7: If no rising edge arrives for floor-equivalent 2·PRESCALE·den/num crystal cycles after the last one, the flag clears. The next edge only starts a new measurement.
- R8: The lower and upper limits are independent signed ppm values and both bounds are inclusive. A positive deviation means the reference is faster than expected.
- R9: Any change of `ratio_sel` clears the flag on the next clock and restarts qualification.
- R10: Codes 12 to 15 are unsupported, and the flag stays 0 while one of them is selected.
- R11: `ref_in` passes through two synchronizer flops. The flag therefore changes no earlier than the second and no later than the third crystal clock edge after the qualifying reference edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Crystal-domain clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_in | input | 1 | Selected reference clock, asynchronous |
| ratio_sel | input | 4 | Reference-to-crystal ratio code |
| lim_lo_ppm | input | PPM_W | Signed lower capture limit in ppm |
| lim_hi_ppm | input | PPM_W | Signed upper capture limit in ppm |
| ref_valid | output | 1 | High when the reference is judged valid |
| hold | output | 1 | High when the tuning loop must keep its last setting |

## Verification
A wrong interval count or a wrong ratio entry shows up at the ports as a flag that rises one interval too early or too late. It can also show as a reference that never qualifies or one that qualifies under the wrong code, and the error appears within about thirteen reference periods. A stuck watchdog leaves the flag high after the reference stops, which is visible two expected periods after the last edge. Limit sign or bound errors show as the flag being cleared by a 1 % slow reference under an asymmetric window, or not being cleared by it. Restart faults show within a few cycles of a code change.

// File: rtl/refmon_pkg.sv
package refmon_pkg;

    localparam int QUAL_PERIODS = 12;
    localparam int PPM_SCALE    = 1000000;
    localparam int DEF_LO_PPM   = -332;
    localparam int DEF_HI_PPM   = 280;

    typedef enum logic [1:0] {
        ST_WAIT = 2'd0,
        ST_QUAL = 2'd1,
        ST_OK   = 2'd2
    } mon_state_e;

    typedef struct packed {
        logic       ok;
        logic [3:0] num;
        logic [3:0] den;
    } ratio_t;

    function automatic ratio_t mk_ratio(input logic [3:0] n, input logic [3:0] d);
        ratio_t r;
        r.ok  = 1'b1;
        r.num = n;
        r.den = d;
        return r;
    endfunction

    function automatic ratio_t decode_ratio(input logic [3:0] code);
        ratio_t r;
        case (code)
            4'd0:    r = mk_ratio(4'd1, 4'd8);
            4'd1:    r = mk_ratio(4'd1, 4'd4);
            4'd2:    r = mk_ratio(4'd1, 4'd3);
            4'd3:    r = mk_ratio(4'd1, 4'd2);
            4'd4:    r = mk_ratio(4'd3, 4'd4);
            4'd5:    r = mk_ratio(4'd1, 4'd1);
            4'd6:    r = mk_ratio(4'd4, 4'd3);
            4'd7:    r = mk_ratio(4'd2, 4'd1);
            4'd8:    r = mk_ratio(4'd3, 4'd1);
            4'd9:    r = mk_ratio(4'd4, 4'd1);
            4'd10:   r = mk_ratio(4'd6, 4'd1);
            4'd11:   r = mk_ratio(4'd8, 4'd1);
            default: begin
                r     = mk_ratio(4'd1, 4'd1);
                r.ok  = 1'b0;
            end
        endcase
        return r;
    endfunction

endpackage

// File: rtl/refmon_edge.sv
module refmon_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic ref_in,
    output logic rise
);
    // sh[0..STAGES-1] synchronizer, sh[STAGES] previous-value flop
    logic [STAGES:0] sh;

    always_ff @(posedge clk) begin
        if (rst) sh <= '0;
        else     sh <= {sh[STAGES-1:0], ref_in};
    end

    assign rise = sh[STAGES-1] & ~sh[STAGES];
endmodule

// File: rtl/refmon_judge.sv
module refmon_judge #(
    parameter int PRESCALE = 4096,
    parameter int PPM_W    = 20,
    parameter int CNT_W    = 17
) (
    input  logic [CNT_W-1:0]        period,
    input  logic [3:0]              num,
    input  logic [3:0]              den,
    input  logic signed [PPM_W-1:0] lim_lo,
    input  logic signed [PPM_W-1:0] lim_hi,
    output logic                    in_range
);
    import refmon_pkg::*;

    logic signed [63:0] per_s, num_s, den_s, lo_s, hi_s, ppm_s;
    logic signed [63:0] base, target, low_side, high_side;

    always_comb begin
        per_s     = signed'(64'(period));
        num_s     = signed'(64'(num));
        den_s     = signed'(64'(den));
        lo_s      = 64'(lim_lo);
        hi_s      = 64'(lim_hi);
        ppm_s     = 64'(PPM_SCALE);
        base      = per_s * num_s;
        target    = 64'(PRESCALE) * den_s * ppm_s;
        low_side  = base * (ppm_s + lo_s);
        high_side = base * (ppm_s + hi_s);
        in_range  = (low_side <= target) && (target <= high_side);
    end
endmodule

// File: rtl/refmon_qual.sv
module refmon_qual
    import refmon_pkg::*;
#(
    parameter int PRESCALE = 4096,
    parameter int CNT_W    = 17,
    parameter int QUAL     = QUAL_PERIODS
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rise,
    input  logic             restart,
    input  ratio_t           rat,
    input  logic             in_range,
    output logic [CNT_W-1:0] period,
    output mon_state_e       state
);
    localparam int GOOD_W = $clog2(QUAL + 1);

    logic [GOOD_W-1:0] good, good_inc;
    logic              wd_hit;

    assign good_inc = (good == GOOD_W'(QUAL)) ? good : good + 1'b1;
    assign wd_hit   = (32'(period) * 32'(rat.num)) >= (32'(2 * PRESCALE) * 32'(rat.den));

    always_ff @(posedge clk) begin
        if (rst || restart || !rat.ok) begin
            state  <= ST_WAIT;
            period <= '0;
            good   <= '0;
        end else if (state == ST_WAIT) begin
            if (rise) begin
                state  <= ST_QUAL;
                period <= CNT_W'(1);
                good   <= '0;
            end
        end else if (rise) begin
            period <= CNT_W'(1);
            if (in_range) begin
                good <= good_inc;
                if (good_inc >= GOOD_W'(QUAL)) state <= ST_OK;
            end else begin
                good  <= '0;
                state <= ST_QUAL;
            end
        end else if (wd_hit) begin
            state  <= ST_WAIT;
            period <= '0;
            good   <= '0;
        end else begin
            period <= period + 1'b1;
        end
    end
endmodule

// File: rtl/ref_valid_monitor.sv
module ref_valid_monitor
    import refmon_pkg::*;
#(
    parameter int PRESCALE    = 4096,
    parameter int PPM_W       = 20,
    parameter int SYNC_STAGES = 2
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    ref_in,
    input  logic [3:0]              ratio_sel,
    input  logic signed [PPM_W-1:0] lim_lo_ppm,
    input  logic signed [PPM_W-1:0] lim_hi_ppm,
    output logic                    ref_valid,
    output logic                    hold
);
    localparam int CNT_W = $clog2(2 * PRESCALE * 8 + 2);

    logic             ref_rise;
    logic [3:0]       ratio_q;
    logic             restart;
    logic             in_range;
    ratio_t           rat;
    logic [CNT_W-1:0] period;
    mon_state_e       state;

    assign rat     = decode_ratio(ratio_sel);
    assign restart = (ratio_sel != ratio_q);

    always_ff @(posedge clk) begin
        ratio_q <= ratio_sel;
    end

    refmon_edge #(.STAGES(SYNC_STAGES)) u_edge (
        .clk    (clk),
        .rst    (rst),
        .ref_in (ref_in),
        .rise   (ref_rise)
    );

    refmon_judge #(.PRESCALE(PRESCALE), .PPM_W(PPM_W), .CNT_W(CNT_W)) u_judge (
        .period   (period),
        .num      (rat.num),
        .den      (rat.den),
        .lim_lo   (lim_lo_ppm),
        .lim_hi   (lim_hi_ppm),
        .in_range (in_range)
    );

    refmon_qual #(.PRESCALE(PRESCALE), .CNT_W(CNT_W), .QUAL(QUAL_PERIODS)) u_qual (
        .clk      (clk),
        .rst      (rst),
        .rise     (ref_rise),
        .restart  (restart),
        .rat      (rat),
        .in_range (in_range),
        .period   (period),
        .state    (state)
    );

    assign ref_valid = (state == ST_OK);
    assign hold      = ~ref_valid;
endmodule

// File: rtl/ref_valid_monitor_chk.sv
module ref_valid_monitor_chk #(
    parameter int PRESCALE = 4096
) (
    input logic       clk,
    input logic       rst,
    input logic       ref_rise,
    input logic       ref_valid,
    input logic [3:0] ratio_sel
);
    localparam int GAP_MAX = 2 * PRESCALE * 8 + 4;

    logic [31:0] gap;

    always_ff @(posedge clk) begin
        if (rst || ref_rise)         gap <= '0;
        else if (gap != 32'hFFFF_FFFF) gap <= gap + 1'b1;
    end

    // R1
    reset_low_chk: assert property (@(posedge clk) rst |=> !ref_valid);

    // R5
    rise_on_edge_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(ref_valid) |-> $past(ref_rise));

    // R9
    ratio_restart_chk: assert property (@(posedge clk) disable iff (rst)
        (ratio_sel != $past(ratio_sel)) |=> !ref_valid);

    // R10
    bad_code_chk: assert property (@(posedge clk) disable iff (rst)
        (ratio_sel > 4'd11) |=> !ref_valid);

    // R7
    silent_ref_chk: assert property (@(posedge clk) disable iff (rst)
        (gap > 32'(GAP_MAX)) |-> !ref_valid);
endmodule

bind ref_valid_monitor ref_valid_monitor_chk #(.PRESCALE(PRESCALE)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .ref_rise  (ref_rise),
    .ref_valid (ref_valid),
    .ratio_sel (ratio_sel)
);

// File: tb/ref_valid_monitor_tb.sv
`timescale 1ns/1ps
module ref_valid_monitor_tb;
    import refmon_pkg::*;

    localparam int  PS    = 256;
    localparam int  PPM_W = 20;
    localparam real TCLK  = 5.0;
    localparam real P1    = PS * TCLK;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ref_in = 1'b0;
    logic [3:0] ratio_sel = 4'd5;
    logic signed [PPM_W-1:0] lim_lo = PPM_W'(DEF_LO_PPM);
    logic signed [PPM_W-1:0] lim_hi = PPM_W'(DEF_HI_PPM);
    logic ref_valid, hold;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(TCLK / 2.0) clk = ~clk;

    ref_valid_monitor #(.PRESCALE(PS), .PPM_W(PPM_W)) u_dut (
        .clk        (clk),
        .rst        (rst),
        .ref_in     (ref_in),
        .ratio_sel  (ratio_sel),
        .lim_lo_ppm (lim_lo),
        .lim_hi_ppm (lim_hi),
        .ref_valid  (ref_valid),
        .hold       (hold)
    );

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: got %b expected %b", req, what, act, exp);
        end
    endtask

    task automatic run_ref(input int k, input real per);
        for (int i = 0; i < k; i++) begin
            ref_in = 1'b1;
            #(per / 2.0);
            ref_in = 1'b0;
            #(per / 2.0);
        end
    endtask

    task automatic set_lims(input int lo, input int hi);
        lim_lo = PPM_W'(lo);
        lim_hi = PPM_W'(hi);
    endtask

    task automatic t_reset();
        repeat (4) @(posedge clk);
        #1;
        chk("R1", "flag in reset", ref_valid, 1'b0);
        chk("R1", "hold in reset", hold, 1'b1);
        @(posedge clk);
        rst = 1'b0;
        #1.3;
        repeat (20) @(posedge clk);
        #1.3;
        chk("R1", "flag after reset, no reference", ref_valid, 1'b0);
    endtask

    task automatic t_qualify();
        set_lims(-20000, 20000);
        run_ref(12, P1);
        chk("R5", "flag after 11 good intervals", ref_valid, 1'b0);
        ref_in = 1'b1;
        #6;
        chk("R11", "flag before sync latency", ref_valid, 1'b0);
        #14;
        chk("R11", "flag after sync latency", ref_valid, 1'b1);
        chk("R2", "hold while valid", hold, 1'b0);
        #(P1 / 2.0 - 20.0);
        ref_in = 1'b0;
        #(P1 / 2.0);
    endtask

    task automatic t_stop();
        #(P1 / 2.0);
        chk("R7", "flag 1.5 periods after last edge", ref_valid, 1'b1);
        #(P1 / 2.0 + 60.0);
        chk("R7", "flag 2 periods after last edge", ref_valid, 1'b0);
        chk("R2", "hold after stop", hold, 1'b1);
        #(P1 - 60.0);
    endtask

    task automatic t_requal();
        run_ref(12, P1);
        chk("R5", "requalify too early", ref_valid, 1'b0);
        run_ref(1, P1);
        chk("R5", "requalify after 12 intervals", ref_valid, 1'b1);
    endtask

    task automatic t_fast();
        run_ref(2, 0.9 * P1);
        chk("R6", "fast interval clears flag", ref_valid, 1'b0);
        run_ref(15, 0.9 * P1);
        chk("R4", "fast reference never qualifies", ref_valid, 1'b0);
    endtask

    task automatic t_asym();
        set_lims(-5000, 20000);
        run_ref(12, P1);
        chk("R8", "nominal, not yet", ref_valid, 1'b0);
        run_ref(1, P1);
        chk("R8", "nominal qualifies", ref_valid, 1'b1);
        run_ref(10, 0.99 * P1);
        chk("R8", "1% fast inside +20000", ref_valid, 1'b1);
        run_ref(2, 1.01 * P1);
        chk("R8", "1% slow outside -5000", ref_valid, 1'b0);
        run_ref(12, P1);
        chk("R5", "drift back, not yet", ref_valid, 1'b0);
        run_ref(1, P1);
        chk("R5", "drift back qualifies", ref_valid, 1'b1);
        set_lims(-20000, 20000);
    endtask

    task automatic t_ratio_change();
        ratio_sel = 4'd7;
        #20;
        chk("R9", "flag after code change", ref_valid, 1'b0);
        ratio_sel = 4'd5;
        #20;
        chk("R9", "flag after code restored", ref_valid, 1'b0);
        run_ref(12, P1);
        chk("R9", "restart, not yet", ref_valid, 1'b0);
        run_ref(1, P1);
        chk("R9", "restart qualifies", ref_valid, 1'b1);
    endtask

    task automatic t_fraction();
        real p3 = P1 / 3.0;
        real p8 = P1 * 8.0;
        ratio_sel = 4'd8;
        #20;
        run_ref(12, p3);
        chk("R3", "n=3, not yet", ref_valid, 1'b0);
        run_ref(1, p3);
        chk("R3", "n=3 qualifies", ref_valid, 1'b1);
        ratio_sel = 4'd9;
        run_ref(20, p3);
        chk("R3", "n=3 reference under n=4 code", ref_valid, 1'b0);
        ratio_sel = 4'd0;
        #20;
        run_ref(12, p8);
        chk("R3", "n=1/8, not yet", ref_valid, 1'b0);
        run_ref(1, p8);
        chk("R3", "n=1/8 qualifies", ref_valid, 1'b1);
    endtask

    task automatic t_unsupported();
        ratio_sel = 4'd13;
        run_ref(20, P1);
        chk("R10", "unsupported code keeps flag low", ref_valid, 1'b0);
        chk("R10", "unsupported code keeps hold", hold, 1'b1);
    endtask

    initial begin
        t_reset();
        t_qualify();
        t_stop();
        t_requal();
        t_fast();
        t_asym();
        t_ratio_change();
        t_fraction();
        t_unsupported();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #800us;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule